// File: doc/BRIEF.md
# Change-Detection Interrupt Controller

This block watches a number of 8-bit digital input ports, already synchronised to its clock, and raises a single active-high interrupt when an armed channel changes. Every channel has one arming bit for rising changes and one for falling changes. A change counts only when the matching direction sense is also switched on globally.

A latched status byte records that a change happened, and in which direction. If a second armed change arrives before the host has acknowledged the first, an overflow flag is also latched. A control byte gates the interrupt output. It has a master enable and separate enables for the change cause and for the overflow cause.

Software reaches all state through a byte-wide synchronous register port. Writes are taken on the clock edge and reads are combinational. The usual sequence is: arm channels, acknowledge stale status through the clear register, then set the control byte. After that the host services each interrupt by reading status and writing the clear register.

Top module: `chg_irq_ctrl`

## Requirements
- R1: After reset the control byte, every arming byte and all status flags are zero, `irq` is low and every register reads 0x00.
- R2: The control byte is at 0x03 and reads back only bits 4:0 (upper bits read 0). For port p, the rising-arm byte sits at 0x42+0x10·p and the falling-arm byte at 0x43+0x10·p. Both read back as written. Unmapped addresses read 0x00.
- R3: A channel whose bit is set in its port's rising-arm byte, going 0→1 between two clock samples while control bit 3 is set, latches status bit 0 (change) and status bit 3 (rising seen). Both are visible after the edge that samples the new value.
- R4: A channel whose bit is set in its port's falling-arm byte, going 1→0 while control bit 4 is set, latches status bit 0 and status bit 4 (falling seen).
- R5: A transition on an unarmed channel, or on an armed channel whose direction sense bit in control is clear, leaves the status byte unchanged.
- R6: An armed change that arrives while status bit 0 is already set, and is not in a cycle that writes the change-clear, sets status bit 1 (overflow).
- R7: Writing the clear register at 0x01 with bit 3 set clears status bits 0, 3 and 4. Writing it with bit 2 set clears status bit 1. Bits written as 0 clear nothing.
- R8: When a change-clear and a new armed change land in the same cycle, status bit 0 stays set and overflow is not raised by that change.
- R9: `irq` equals control bit 2 AND ((status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1)). Status bit 2 reads back this value.
- R10: Writing 0x00 to control drops `irq` at once, and the latched change, rising and falling flags are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | NPORTS*8 | Synchronised input channels, port p at bits 8p+7:8p |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Active-high interrupt |

## Verification
The hardest case to reach from the ports is a change-clear write and a fresh armed change arriving on the same clock edge. The bench first parks one input one step away from an armed transition. It then issues the clear write and the input change together in one driver call, so both are sampled by the same edge. Overflow needs a similar setup: the bench toggles an unarmed direction first, so that the next armed transition lands while the change flag is still held. This is done once with the change cause enabled and once with only the overflow cause enabled.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;

  localparam int ADDR_W      = 8;
  localparam int REG_W       = 8;
  localparam int PORT_W      = 8;
  localparam int PORT_STRIDE = 'h10;
  localparam int RISE_BASE   = 'h42;
  localparam int FALL_BASE   = 'h43;

  localparam logic [ADDR_W-1:0] A_CLEAR  = 8'h01;
  localparam logic [ADDR_W-1:0] A_STATUS = 8'h02;
  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h03;

  localparam int CLR_EDGE_BIT = 3;
  localparam int CLR_OVF_BIT  = 2;

  typedef struct packed {
    logic fall_sense;
    logic rise_sense;
    logic master;
    logic ovf_en;
    logic edge_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [ADDR_W-1:0] rise_addr(input int p);
    return ADDR_W'(RISE_BASE + p * PORT_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] fall_addr(input int p);
    return ADDR_W'(FALL_BASE + p * PORT_STRIDE);
  endfunction

  function automatic logic [PORT_W-1:0] armed_up(input logic [PORT_W-1:0] prev,
                                                 input logic [PORT_W-1:0] cur,
                                                 input logic [PORT_W-1:0] arm);
    return ~prev & cur & arm;
  endfunction

  function automatic logic [PORT_W-1:0] armed_down(input logic [PORT_W-1:0] prev,
                                                   input logic [PORT_W-1:0] cur,
                                                   input logic [PORT_W-1:0] arm);
    return prev & ~cur & arm;
  endfunction

  function automatic logic irq_of(input ctrl_t c, input logic chg, input logic ovf);
    return c.master & ((chg & c.edge_en) | (ovf & c.ovf_en));
  endfunction

  function automatic logic [REG_W-1:0] status_byte(input logic chg, input logic ovf,
                                                   input logic irq, input logic up,
                                                   input logic down);
    return {3'b000, down, up, irq, ovf, chg};
  endfunction

endpackage

// File: rtl/chg_irq_sampler.sv
module chg_irq_sampler
  import chg_irq_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*PORT_W-1:0] din,
  input  logic [NPORTS*PORT_W-1:0] rise_arm,
  input  logic [NPORTS*PORT_W-1:0] fall_arm,
  input  logic                     rise_sense,
  input  logic                     fall_sense,
  output logic                     rise_ev,
  output logic                     fall_ev
);

  logic [NPORTS-1:0] port_up;
  logic [NPORTS-1:0] port_down;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [PORT_W-1:0] prev_q;
    logic [PORT_W-1:0] cur;

    assign cur = din[p*PORT_W +: PORT_W];

    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur;
    end

    assign port_up[p]   = |armed_up(prev_q, cur, rise_arm[p*PORT_W +: PORT_W]);
    assign port_down[p] = |armed_down(prev_q, cur, fall_arm[p*PORT_W +: PORT_W]);
  end

  assign rise_ev = rise_sense & (|port_up);
  assign fall_ev = fall_sense & (|port_down);

endmodule

// File: rtl/chg_irq_regs.sv
module chg_irq_regs
  import chg_irq_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [REG_W-1:0]         wdata,
  input  logic [REG_W-1:0]         status,
  output ctrl_t                    ctrl,
  output logic [NPORTS*PORT_W-1:0] rise_arm,
  output logic [NPORTS*PORT_W-1:0] fall_arm,
  output logic                     clr_edge,
  output logic                     clr_ovf,
  output logic [REG_W-1:0]         rdata
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                         ctrl_q <= '0;
    else if (wr_en && addr == A_CTRL)   ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_arm
    logic [PORT_W-1:0] up_q;
    logic [PORT_W-1:0] down_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        up_q   <= '0;
        down_q <= '0;
      end else if (wr_en) begin
        if (addr == rise_addr(p)) up_q   <= wdata;
        if (addr == fall_addr(p)) down_q <= wdata;
      end
    end

    assign rise_arm[p*PORT_W +: PORT_W] = up_q;
    assign fall_arm[p*PORT_W +: PORT_W] = down_q;
  end

  assign ctrl     = ctrl_q;
  assign clr_edge = wr_en && (addr == A_CLEAR) && wdata[CLR_EDGE_BIT];
  assign clr_ovf  = wr_en && (addr == A_CLEAR) && wdata[CLR_OVF_BIT];

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)   rdata = REG_W'(ctrl_q);
    if (addr == A_STATUS) rdata = status;
    for (int p = 0; p < NPORTS; p++) begin
      if (addr == rise_addr(p)) rdata = rise_arm[p*PORT_W +: PORT_W];
      if (addr == fall_addr(p)) rdata = fall_arm[p*PORT_W +: PORT_W];
    end
  end

endmodule

// File: rtl/chg_irq_status.sv
module chg_irq_status
  import chg_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             clr_edge,
  input  logic             clr_ovf,
  input  ctrl_t            ctrl,
  output logic             edge_ev,
  output logic             edge_st,
  output logic             ovf_st,
  output logic             irq,
  output logic [REG_W-1:0] status
);

  logic up_st;
  logic down_st;
  logic ovf_ev;

  assign edge_ev = rise_ev | fall_ev;
  assign ovf_ev  = edge_ev & edge_st & ~clr_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_st <= 1'b0;
      ovf_st  <= 1'b0;
      up_st   <= 1'b0;
      down_st <= 1'b0;
    end else begin
      edge_st <= edge_ev | (edge_st & ~clr_edge);
      ovf_st  <= ovf_ev  | (ovf_st  & ~clr_ovf);
      up_st   <= rise_ev | (up_st   & ~clr_edge);
      down_st <= fall_ev | (down_st & ~clr_edge);
    end
  end

  assign irq    = irq_of(ctrl, edge_st, ovf_st);
  assign status = status_byte(edge_st, ovf_st, irq, up_st, down_st);

endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
  import chg_irq_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*PORT_W-1:0] din,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [REG_W-1:0]         wdata,
  output logic [REG_W-1:0]         rdata,
  output logic                     irq
);

  ctrl_t                    ctrl;
  logic [NPORTS*PORT_W-1:0] rise_arm;
  logic [NPORTS*PORT_W-1:0] fall_arm;
  logic                     clr_edge;
  logic                     clr_ovf;
  logic                     rise_ev;
  logic                     fall_ev;
  logic                     edge_ev;
  logic                     edge_st;
  logic                     ovf_st;
  logic                     master_en;
  logic [REG_W-1:0]         status;

  assign master_en = ctrl.master;

  chg_irq_regs #(.NPORTS(NPORTS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .status   (status),
    .ctrl     (ctrl),
    .rise_arm (rise_arm),
    .fall_arm (fall_arm),
    .clr_edge (clr_edge),
    .clr_ovf  (clr_ovf),
    .rdata    (rdata)
  );

  chg_irq_sampler #(.NPORTS(NPORTS)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (din),
    .rise_arm   (rise_arm),
    .fall_arm   (fall_arm),
    .rise_sense (ctrl.rise_sense),
    .fall_sense (ctrl.fall_sense),
    .rise_ev    (rise_ev),
    .fall_ev    (fall_ev)
  );

  chg_irq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .clr_edge (clr_edge),
    .clr_ovf  (clr_ovf),
    .ctrl     (ctrl),
    .edge_ev  (edge_ev),
    .edge_st  (edge_st),
    .ovf_st   (ovf_st),
    .irq      (irq),
    .status   (status)
  );

endmodule

// File: rtl/chg_irq_ctrl_chk.sv
module chg_irq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic edge_ev,
  input logic clr_edge,
  input logic clr_ovf,
  input logic edge_st,
  input logic ovf_st,
  input logic master_en,
  input logic irq
);

  a_r3_change_latches: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev |=> edge_st);

  a_r5_no_spurious_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_st && !edge_ev) |=> !edge_st);

  a_r6_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ev && edge_st && !clr_edge) |=> ovf_st);

  a_r7_clear_change: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && !edge_ev) |=> !edge_st);

  a_r7_clear_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !(edge_ev && edge_st && !clr_edge)) |=> !ovf_st);

  a_r8_clear_loses: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ev && clr_edge && !ovf_st) |=> (edge_st && !ovf_st));

  a_r9_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> !irq);

  a_r9_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_st && !ovf_st) |-> !irq);

endmodule

bind chg_irq_ctrl chg_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .edge_ev   (edge_ev),
  .clr_edge  (clr_edge),
  .clr_ovf   (clr_ovf),
  .edge_st   (edge_st),
  .ovf_st    (ovf_st),
  .master_en (master_en),
  .irq       (irq)
);

// File: tb/chg_irq_ctrl_tb.sv
module chg_irq_ctrl_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP*8-1:0] din = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] a;
    logic [7:0] d;
    logic       q;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  chg_irq_ctrl #(.NPORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // expected status byte: change, overflow, irq, rising, falling
  function automatic logic [7:0] st(input bit c, input bit o, input bit i,
                                    input bit u, input bit d);
    return (8'(c) << 0) | (8'(o) << 1) | (8'(i) << 2) | (8'(u) << 3) | (8'(d) << 4);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step();
    wr_en = 1'b1; addr = a; wdata = d;
  endtask

  task automatic drive(input logic [NP*8-1:0] v);
    step();
    din = v;
  endtask

  task automatic wr_drive(input logic [7:0] a, input logic [7:0] d,
                          input logic [NP*8-1:0] v);
    step();
    wr_en = 1'b1; addr = a; wdata = d; din = v;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] d,
                           input logic q, input string tag);
    exp_t it;
    step();
    addr = a;
    it.a = a; it.d = d; it.q = q; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        checks++;
        if (rdata !== it.d || irq !== it.q) begin
          errors++;
          $display("FAIL %s addr %h: rdata %h irq %b, expected rdata %h irq %b",
                   it.tag, it.a, rdata, irq, it.d, it.q);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_rd(8'h03, 8'h00, 1'b0, "R1");
    expect_rd(8'h02, 8'h00, 1'b0, "R1");
    expect_rd(8'h42, 8'h00, 1'b0, "R1");

    // R2 register placement and readback
    wr(8'h42, 8'h01);
    wr(8'h63, 8'h80);
    wr(8'h72, 8'hA5);
    wr(8'h03, 8'hFF);
    expect_rd(8'h42, 8'h01, 1'b0, "R2");
    expect_rd(8'h63, 8'h80, 1'b0, "R2");
    expect_rd(8'h72, 8'hA5, 1'b0, "R2");
    expect_rd(8'h03, 8'h1F, 1'b0, "R2");
    expect_rd(8'h44, 8'h00, 1'b0, "R2");

    // R5 armed channel but direction sense off, then unarmed channels
    wr(8'h03, 8'h07);
    drive(32'h0000_0001);
    expect_rd(8'h02, 8'h00, 1'b0, "R5");
    wr(8'h03, 8'h1F);
    drive(32'h0000_0000);
    drive(32'h0000_0002);
    expect_rd(8'h02, 8'h00, 1'b0, "R5");

    // R3 rising change on port 0 bit 0; R9 status bit 2 mirrors irq
    drive(32'h0000_0003);
    expect_rd(8'h02, st(1,0,1,1,0), 1'b1, "R3");

    // R7 clear change flags
    wr(8'h01, 8'h08);
    expect_rd(8'h02, 8'h00, 1'b0, "R7");

    // R4 falling change on port 2 bit 7 (rising there is unarmed)
    drive(32'h0080_0003);
    expect_rd(8'h02, 8'h00, 1'b0, "R5");
    drive(32'h0000_0003);
    expect_rd(8'h02, st(1,0,1,0,1), 1'b1, "R4");

    // R6 second change while flag held
    drive(32'h0000_0002);
    drive(32'h0000_0003);
    expect_rd(8'h02, st(1,1,1,1,1), 1'b1, "R6");

    // R7 overflow-only clear, then a zero write clears nothing
    wr(8'h01, 8'h04);
    expect_rd(8'h02, st(1,0,1,1,1), 1'b1, "R7");
    wr(8'h01, 8'h00);
    expect_rd(8'h02, st(1,0,1,1,1), 1'b1, "R7");

    // R10 control to zero drops irq, flags kept
    wr(8'h03, 8'h00);
    expect_rd(8'h02, st(1,0,0,1,1), 1'b0, "R10");

    // R9 overflow cause only
    wr(8'h03, 8'h1E);
    expect_rd(8'h02, st(1,0,0,1,1), 1'b0, "R9");
    drive(32'h0000_0002);
    drive(32'h0000_0003);
    expect_rd(8'h02, st(1,1,1,1,1), 1'b1, "R9");
    wr(8'h01, 8'h0C);
    expect_rd(8'h02, 8'h00, 1'b0, "R7");

    // R8 clear and new change in the same cycle
    wr(8'h03, 8'h1F);
    drive(32'h0000_0002);
    drive(32'h0000_0003);
    expect_rd(8'h02, st(1,0,1,1,0), 1'b1, "R3");
    drive(32'h0000_0002);
    wr_drive(8'h01, 8'h08, 32'h0000_0003);
    expect_rd(8'h02, st(1,0,1,1,0), 1'b1, "R8");

    // R3 another port: port 3 bit 0
    wr(8'h01, 8'h08);
    expect_rd(8'h02, 8'h00, 1'b0, "R7");
    drive(32'h0100_0003);
    expect_rd(8'h02, st(1,0,1,1,0), 1'b1, "R3");

    step();
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule